// File: doc/BRIEF.md
# Serial Port Transmit/Receive Queue Controller

This block sits between a serial port's host-side register interface and its bit-level shifter. It keeps a 128-byte transmit queue and a smaller receive queue. It raises a low-water flag whenever the transmit queue has drained to a programmable level. It also owns the port's handshake pins and its internal loopback path. A single 6-bit control field, written through `cfg_we`/`cfg_wdata`, picks the low-water level, enables hardware flow control, clears either queue, and turns on loopback.

Bytes enter the transmit queue through `tx_push`. They are offered to the shifter on `ser_tx_valid`/`ser_tx_byte`, and one leaves on every cycle in which the shifter asserts `ser_tx_ready` while a byte is offered. Received bytes enter through `rx_push` and leave through `rx_pop`. When flow control is enabled, a deasserted clear-to-send holds back the next byte. Loopback ties the shifter's serial output and request-to-send back onto its own inputs.

Top module: `sio_fifo_ctrl`

## Requirements
- R1: After reset, every control bit is 0, both queue counts are 0, `tx_low_flag` is 1, `ser_tx_valid` is 0, `pin_rts_n` is 0, and `pin_txd` follows `ser_txd`.
- R2: The transmit queue holds at most 128 bytes. A push while it is full is dropped. Bytes leave in the order they were pushed, and the oldest byte is presented on `ser_tx_byte`.
- R3: `tx_low_flag` is 1 exactly when the transmit count is at or below the level chosen by control bits [1:0]: 00 gives 64, 01 gives 32, 10 gives 4, 11 gives 0. The flag follows the current count and the current code.
- R4: A push and a pop accepted in the same cycle leave the transmit count unchanged and keep byte order.
- R5: Writing control bit [3] as 1 empties the transmit queue at the clock edge that captures the write. While that bit stays 1, the queue stays empty and pushes are ignored.
- R6: Writing control bit [4] as 1 empties the receive queue in the same way and leaves the transmit queue untouched.
- R7: With control bit [2] (flow-control enable) at 0, `pin_cts_n` has no effect on `ser_tx_valid`, and `pin_rts_n` is driven 0.
- R8: With control bit [2] at 1, `pin_cts_n` high withholds `ser_tx_valid` so no byte leaves, `pin_cts_n` low allows it, and `pin_rts_n` follows `ser_rts_n`.
- R9: With control bit [5] (loopback) at 1, `ser_rxd` carries `ser_txd`, `pin_txd` is held 1, `pin_rxd` is ignored, and the internal request-to-send replaces `pin_cts_n` as the clear-to-send source.
- R10: The receive queue keeps byte order, and a pop while it is empty leaves its count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control field write strobe |
| cfg_wdata | input | 6 | Control field: [1:0] level code, [2] flow-control enable, [3] transmit clear, [4] receive clear, [5] loopback |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to push |
| tx_count | output | 8 | Bytes held in the transmit queue |
| tx_low_flag | output | 1 | Transmit count at or below the selected level |
| ser_tx_ready | input | 1 | Shifter can take a byte this cycle |
| ser_tx_valid | output | 1 | A byte is offered to the shifter |
| ser_tx_byte | output | 8 | Oldest transmit byte |
| ser_txd | input | 1 | Serial output from the shifter |
| ser_rxd | output | 1 | Serial input to the receiver |
| ser_rts_n | input | 1 | Receiver's request-to-send, active low |
| rx_push | input | 1 | Push a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| rx_count | output | 5 | Bytes held in the receive queue |
| pin_txd | output | 1 | External serial output |
| pin_rxd | input | 1 | External serial input |
| pin_rts_n | output | 1 | External request-to-send, active low |
| pin_cts_n | input | 1 | External clear-to-send, active low |

## Verification
A host push and a shifter pop can land on the transmit queue in the same cycle. The bench provokes this by holding `tx_push` and `ser_tx_ready` together for one cycle with 127 bytes queued. It then checks that the count still reads 127 and that the presented byte has moved on by one. A clear written in the same window as pushes is also covered: the queue must read empty at the edge of the write and must stay empty while further pushes arrive.

// File: rtl/sio_pkg.sv
package sio_pkg;

    // Control field, MSB first: loop, rx_clr, tx_clr, mcen, trig[1:0]
    typedef struct packed {
        logic       loop;
        logic       rx_clr;
        logic       tx_clr;
        logic       mcen;
        logic [1:0] trig;
    } sio_ctrl_t;

    localparam int CTRL_W = $bits(sio_ctrl_t);

endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
    parameter  int W     = 8,
    parameter  int DEPTH = 128,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push_ok;
    logic     pop_ok;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push && !flush && (st_q.cnt != CW'(DEPTH));
        pop_ok  = pop  && !flush && (st_q.cnt != '0);
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wr = ptr_inc(st_q.wr);
            if (pop_ok)  st_d.rd = ptr_inc(st_q.rd);
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr] <= wdata;
    end

    assign rdata = mem[st_q.rd];
    assign count = st_q.cnt;

endmodule

// File: rtl/sio_tx_level.sv
module sio_tx_level #(
    parameter  int DEPTH = 128,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [1:0]    code,
    output logic          low
);

    localparam int LVL_HALF    = DEPTH / 2;
    localparam int LVL_QUARTER = DEPTH / 4;
    localparam int LVL_NEAR    = 4;

    logic [CW-1:0] level;

    always_comb begin
        case (code)
            2'b00:   level = CW'(LVL_HALF);
            2'b01:   level = CW'(LVL_QUARTER);
            2'b10:   level = CW'(LVL_NEAR);
            default: level = '0;
        endcase
        low = (count <= level);
    end

endmodule

// File: rtl/sio_line_mux.sv
module sio_line_mux (
    input  logic loop,
    input  logic mcen,
    input  logic ser_txd,
    input  logic pin_rxd,
    input  logic ser_rts_n,
    input  logic pin_cts_n,
    output logic pin_txd,
    output logic ser_rxd,
    output logic pin_rts_n,
    output logic cts_ok
);

    logic rts_int_n;
    logic cts_src_n;

    always_comb begin
        rts_int_n = mcen ? ser_rts_n : 1'b0;
        cts_src_n = loop ? rts_int_n : pin_cts_n;
        cts_ok    = !mcen || !cts_src_n;
        pin_rts_n = rts_int_n;
        pin_txd   = loop ? 1'b1 : ser_txd;
        ser_rxd   = loop ? ser_txd : pin_rxd;
    end

endmodule

// File: rtl/sio_fifo_ctrl.sv
module sio_fifo_ctrl
    import sio_pkg::*;
#(
    parameter  int TX_DEPTH = 128,
    parameter  int RX_DEPTH = 16,
    parameter  int DW       = 8,
    localparam int TX_CW    = $clog2(TX_DEPTH + 1),
    localparam int RX_CW    = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [5:0]       cfg_wdata,
    input  logic             tx_push,
    input  logic [DW-1:0]    tx_wdata,
    output logic [TX_CW-1:0] tx_count,
    output logic             tx_low_flag,
    input  logic             ser_tx_ready,
    output logic             ser_tx_valid,
    output logic [DW-1:0]    ser_tx_byte,
    input  logic             ser_txd,
    output logic             ser_rxd,
    input  logic             ser_rts_n,
    input  logic             rx_push,
    input  logic [DW-1:0]    rx_wdata,
    input  logic             rx_pop,
    output logic [DW-1:0]    rx_rdata,
    output logic [RX_CW-1:0] rx_count,
    output logic             pin_txd,
    input  logic             pin_rxd,
    output logic             pin_rts_n,
    input  logic             pin_cts_n
);

    sio_ctrl_t ctrl_d, ctrl_q;
    logic      tx_flush;
    logic      rx_flush;
    logic      tx_pop;
    logic      cts_ok;
    logic      mcen_q;
    logic      loop_q;
    logic      txclr_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (cfg_we) ctrl_d = sio_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign mcen_q   = ctrl_q.mcen;
    assign loop_q   = ctrl_q.loop;
    assign txclr_q  = ctrl_q.tx_clr;
    assign tx_flush = ctrl_d.tx_clr;
    assign rx_flush = ctrl_d.rx_clr;

    assign ser_tx_valid = (tx_count != '0) && cts_ok && !tx_flush;
    assign tx_pop       = ser_tx_valid && ser_tx_ready;

    sio_byte_fifo #(.W(DW), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (ser_tx_byte),
        .count (tx_count)
    );

    sio_byte_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_count)
    );

    sio_tx_level #(.DEPTH(TX_DEPTH)) u_level (
        .count (tx_count),
        .code  (ctrl_q.trig),
        .low   (tx_low_flag)
    );

    sio_line_mux u_lines (
        .loop      (ctrl_q.loop),
        .mcen      (ctrl_q.mcen),
        .ser_txd   (ser_txd),
        .pin_rxd   (pin_rxd),
        .ser_rts_n (ser_rts_n),
        .pin_cts_n (pin_cts_n),
        .pin_txd   (pin_txd),
        .ser_rxd   (ser_rxd),
        .pin_rts_n (pin_rts_n),
        .cts_ok    (cts_ok)
    );

endmodule

// File: rtl/sio_fifo_ctrl_chk.sv
module sio_fifo_ctrl_chk #(
    parameter  int TX_DEPTH = 128,
    parameter  int RX_DEPTH = 16,
    localparam int TX_CW    = $clog2(TX_DEPTH + 1),
    localparam int RX_CW    = $clog2(RX_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [5:0]       cfg_wdata,
    input logic             tx_push,
    input logic             ser_tx_ready,
    input logic             ser_tx_valid,
    input logic [TX_CW-1:0] tx_count,
    input logic             tx_low_flag,
    input logic [RX_CW-1:0] rx_count,
    input logic             mcen_q,
    input logic             loop_q,
    input logic             txclr_q,
    input logic             pin_cts_n,
    input logic             pin_rts_n,
    input logic             pin_txd,
    input logic             ser_txd,
    input logic             ser_rxd
);

    assert_tx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= TX_CW'(TX_DEPTH));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == TX_CW'(TX_DEPTH)) && !(ser_tx_ready && ser_tx_valid) && !cfg_we
        |=> tx_count == TX_CW'(TX_DEPTH));

    assert_empty_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |-> tx_low_flag);

    assert_above_max_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count > TX_CW'(TX_DEPTH / 2)) |-> !tx_low_flag);

    assert_push_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push && ser_tx_ready && ser_tx_valid && (tx_count < TX_CW'(TX_DEPTH))
        && !cfg_we && !txclr_q |=> $stable(tx_count));

    assert_tx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[3] |=> tx_count == '0);

    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        txclr_q && !cfg_we |=> tx_count == '0);

    assert_rx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[4] |=> rx_count == '0);

    assert_rts_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mcen_q |-> !pin_rts_n);

    assert_cts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mcen_q && !loop_q && pin_cts_n |-> !ser_tx_valid);

    assert_loop_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
        loop_q |-> pin_txd && (ser_rxd == ser_txd));

endmodule

bind sio_fifo_ctrl sio_fifo_ctrl_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .tx_push      (tx_push),
    .ser_tx_ready (ser_tx_ready),
    .ser_tx_valid (ser_tx_valid),
    .tx_count     (tx_count),
    .tx_low_flag  (tx_low_flag),
    .rx_count     (rx_count),
    .mcen_q       (mcen_q),
    .loop_q       (loop_q),
    .txclr_q      (txclr_q),
    .pin_cts_n    (pin_cts_n),
    .pin_rts_n    (pin_rts_n),
    .pin_txd      (pin_txd),
    .ser_txd      (ser_txd),
    .ser_rxd      (ser_rxd)
);

// File: tb/sio_fifo_ctrl_tb.sv
module sio_fifo_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic       tx_push = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic [7:0] tx_count;
    logic       tx_low_flag;
    logic       ser_tx_ready = 1'b0;
    logic       ser_tx_valid;
    logic [7:0] ser_tx_byte;
    logic       ser_txd = 1'b1;
    logic       ser_rxd;
    logic       ser_rts_n = 1'b0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_wdata = '0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_rdata;
    logic [4:0] rx_count;
    logic       pin_txd;
    logic       pin_rxd = 1'b1;
    logic       pin_rts_n;
    logic       pin_cts_n = 1'b0;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    sio_fifo_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .tx_push      (tx_push),
        .tx_wdata     (tx_wdata),
        .tx_count     (tx_count),
        .tx_low_flag  (tx_low_flag),
        .ser_tx_ready (ser_tx_ready),
        .ser_tx_valid (ser_tx_valid),
        .ser_tx_byte  (ser_tx_byte),
        .ser_txd      (ser_txd),
        .ser_rxd      (ser_rxd),
        .ser_rts_n    (ser_rts_n),
        .rx_push      (rx_push),
        .rx_wdata     (rx_wdata),
        .rx_pop       (rx_pop),
        .rx_rdata     (rx_rdata),
        .rx_count     (rx_count),
        .pin_txd      (pin_txd),
        .pin_rxd      (pin_rxd),
        .pin_rts_n    (pin_rts_n),
        .pin_cts_n    (pin_cts_n)
    );

    // {level code[1:0], bytes to queue[7:0], expected flag}
    localparam int NVEC = 10;
    localparam logic [10:0] LVL_VEC [NVEC] = '{
        {2'b00, 8'd64,  1'b1}, {2'b00, 8'd65,  1'b0},
        {2'b01, 8'd32,  1'b1}, {2'b01, 8'd33,  1'b0},
        {2'b10, 8'd4,   1'b1}, {2'b10, 8'd5,   1'b0},
        {2'b11, 8'd0,   1'b1}, {2'b11, 8'd1,   1'b0},
        {2'b00, 8'd0,   1'b1}, {2'b11, 8'd128, 1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic [5:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic push_tx(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tx_push  = 1'b1;
            tx_wdata = base + 8'(i);
        end
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] v);
        @(negedge clk);
        rx_push  = 1'b1;
        rx_wdata = v;
        @(negedge clk);
        rx_push  = 1'b0;
    endtask

    task automatic pulse_pop_rx();
        @(negedge clk);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic pulse_ready();
        @(negedge clk);
        ser_tx_ready = 1'b1;
        @(negedge clk);
        ser_tx_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "tx_count", int'(tx_count), 0);
        chk("R1", "rx_count", int'(rx_count), 0);
        chk("R1", "tx_low_flag", int'(tx_low_flag), 1);
        chk("R1", "ser_tx_valid", int'(ser_tx_valid), 0);
        chk("R1", "pin_rts_n", int'(pin_rts_n), 0);
        chk("R1", "pin_txd", int'(pin_txd), 1);

        // R3 level table walk
        for (int v = 0; v < NVEC; v++) begin
            cfg({4'b0010, LVL_VEC[v][10:9]});
            cfg({4'b0000, LVL_VEC[v][10:9]});
            push_tx(int'(LVL_VEC[v][8:1]), 8'h00);
            chk("R3", "queued count", int'(tx_count), int'(LVL_VEC[v][8:1]));
            chk("R3", "tx_low_flag", int'(tx_low_flag), int'(LVL_VEC[v][0]));
        end

        // R2 capacity, drop on full, ordering
        cfg(6'h08);
        cfg(6'h00);
        push_tx(130, 8'h00);
        chk("R2", "count after 130 pushes", int'(tx_count), 128);
        chk("R2", "head byte", int'(ser_tx_byte), 0);
        pulse_ready();
        chk("R2", "count after pop", int'(tx_count), 127);
        chk("R2", "next head", int'(ser_tx_byte), 1);

        // R4 push and pop in one cycle
        @(negedge clk);
        ser_tx_ready = 1'b1;
        tx_push      = 1'b1;
        tx_wdata     = 8'hAA;
        @(negedge clk);
        ser_tx_ready = 1'b0;
        tx_push      = 1'b0;
        chk("R4", "count unchanged", int'(tx_count), 127);
        chk("R4", "head advanced", int'(ser_tx_byte), 2);

        // R5 transmit clear and hold
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = 6'h08;
        @(negedge clk);
        cfg_we    = 1'b0;
        chk("R5", "count at clear edge", int'(tx_count), 0);
        push_tx(3, 8'h40);
        chk("R5", "pushes ignored while held", int'(tx_count), 0);
        cfg(6'h00);
        push_tx(1, 8'h5C);
        chk("R5", "count after release", int'(tx_count), 1);
        chk("R5", "head after release", int'(ser_tx_byte), 8'h5C);

        // R10 receive ordering
        push_rx(8'h11);
        push_rx(8'h22);
        push_rx(8'h33);
        chk("R10", "rx count", int'(rx_count), 3);
        chk("R10", "rx head", int'(rx_rdata), 8'h11);
        pulse_pop_rx();
        chk("R10", "rx head after pop", int'(rx_rdata), 8'h22);
        chk("R10", "rx count after pop", int'(rx_count), 2);

        // R6 receive clear leaves transmit alone
        cfg(6'h10);
        chk("R6", "rx count cleared", int'(rx_count), 0);
        chk("R6", "tx count kept", int'(tx_count), 1);
        cfg(6'h00);

        // R10 pop on empty
        pulse_pop_rx();
        chk("R10", "rx count after empty pop", int'(rx_count), 0);

        // R7 flow control off
        @(negedge clk);
        pin_cts_n = 1'b1;
        ser_rts_n = 1'b1;
        @(negedge clk);
        chk("R7", "valid with cts high", int'(ser_tx_valid), 1);
        chk("R7", "rts forced low", int'(pin_rts_n), 0);

        // R8 flow control on
        cfg(6'h04);
        chk("R8", "valid held by cts", int'(ser_tx_valid), 0);
        chk("R8", "rts follows request", int'(pin_rts_n), 1);
        pulse_ready();
        chk("R8", "no pop while held", int'(tx_count), 1);
        @(negedge clk);
        pin_cts_n = 1'b0;
        @(negedge clk);
        chk("R8", "valid with cts low", int'(ser_tx_valid), 1);

        // R9 loopback
        cfg(6'h24);
        @(negedge clk);
        ser_txd = 1'b0;
        pin_rxd = 1'b1;
        @(negedge clk);
        chk("R9", "pin_txd idle", int'(pin_txd), 1);
        chk("R9", "rxd from txd low", int'(ser_rxd), 0);
        ser_txd = 1'b1;
        pin_rxd = 1'b0;
        @(negedge clk);
        chk("R9", "rxd from txd high", int'(ser_rxd), 1);
        ser_rts_n = 1'b1;
        pin_cts_n = 1'b0;
        @(negedge clk);
        chk("R9", "cts from internal rts high", int'(ser_tx_valid), 0);
        ser_rts_n = 1'b0;
        pin_cts_n = 1'b1;
        @(negedge clk);
        chk("R9", "cts from internal rts low", int'(ser_tx_valid), 1);

        done = 1'b1;
        finish_run();
    end

endmodule